// File: doc/BRIEF.md
# Prioritized Transmit Mailbox Scheduler

This block decides which of a set of message mailboxes is passed next to a CAN protocol engine for sending, and it owns the per-mailbox transmit status: pending requests, pending cancellations, and the success and abort acknowledge flags. Software drives one-cycle write masks to post requests, ask for cancellation and clear acknowledge flags. The engine sees a start pulse together with a mailbox index, and it answers with a completion pulse or an abort pulse.

Two selection modes exist. In normal mode, every mailbox carries a 5-bit priority and the largest value wins, with ties going to the higher mailbox number. In compatibility mode, only the lower sixteen mailboxes take part and the priority fields are ignored: the highest mailbox number wins. A mailbox handed to the engine stays locked until the engine reports back. Only then is the next candidate chosen, and only while the engine signals an idle bus.

Top module: `tx_mbox_sched`

## Requirements
- R1: After reset, the pending, cancel, success-ack and abort-ack bitmaps are all zero, `eng_start` and `eng_cancel` are low and no mailbox is locked.
- R2: A 1 in `sw_req_set` bit i sets pending bit i at the next edge. A 0 in the mask leaves the bit unchanged, so software can never clear a request.
- R3: Only a mailbox whose pending bit is set, whose `mb_enable` bit is 1, whose `mb_is_rx` bit is 0 and whose cancel bit is clear can be started. In compatibility mode, only mailboxes 0 to 15 qualify.
- R4: In normal mode (`compat_mode`=0), the started mailbox has the largest priority value `mb_prio[i*5 +: 5]` among qualifying mailboxes. On equal priority, the higher mailbox number wins.
- R5: In compatibility mode (`compat_mode`=1), the started mailbox is the highest-numbered qualifying mailbox, whatever its priority field holds.
- R6: A start happens only while no mailbox is locked and `eng_bus_idle` was high at the selecting edge. `eng_start` is a one-cycle pulse in the cycle after that edge. `eng_mb_idx` then holds the locked index until `eng_done` or `eng_abort`.
- R7: `eng_done` while a mailbox is locked clears that mailbox's pending and cancel bits, sets its success-ack bit and releases the lock. If `eng_done` and `eng_abort` arrive together, done takes effect.
- R8: `eng_abort` (without done) while a mailbox is locked clears its pending and cancel bits, sets its abort-ack bit and releases the lock. `abort_irq` is high whenever any abort-ack bit is set.
- R9: A cancel bit set on a mailbox that is not locked is cleared at the next edge; if that mailbox was pending, its pending bit is cleared and its abort-ack bit is set. A cancel bit on the locked mailbox is shown on `eng_cancel` and stays set until done or abort.
- R10: When a software set of a pending or cancel bit meets a hardware clear of that bit in the same cycle, the bit ends up set.
- R11: A 1 in `sw_tack_clr` or `sw_aack_clr` clears the matching ack bit, and a 0 has no effect. If a hardware set meets a software clear in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| compat_mode | input | 1 | 1: sixteen mailboxes, selection by number only |
| mb_enable | input | 32 | Per-mailbox enable |
| mb_is_rx | input | 32 | Per-mailbox direction, 1 = receive |
| mb_prio | input | 160 | Priority of mailbox i at bits i*5 +: 5 |
| sw_req_set | input | 32 | Software mask, 1 posts a transmit request |
| sw_cancel_set | input | 32 | Software mask, 1 requests cancellation |
| sw_tack_clr | input | 32 | Software mask, 1 clears a success-ack bit |
| sw_aack_clr | input | 32 | Software mask, 1 clears an abort-ack bit |
| eng_bus_idle | input | 1 | Engine reports an idle bus |
| eng_done | input | 1 | Engine pulse, locked mailbox sent |
| eng_abort | input | 1 | Engine pulse, locked mailbox abandoned |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_mb_idx | output | 5 | Index of the locked mailbox |
| eng_cancel | output | 1 | Locked mailbox has a pending cancel |
| tx_pending | output | 32 | Pending request bitmap |
| tx_cancel | output | 32 | Pending cancel bitmap |
| tx_ack | output | 32 | Success-ack bitmap |
| tx_abort_ack | output | 32 | Abort-ack bitmap |
| abort_irq | output | 1 | Any abort-ack bit set |

## Verification
Software writes and engine reports can fall on the same edge for the same mailbox: a cancel or a new request written while the engine reports done, and an abort-ack clear written while the engine reports an abort. The bench provokes each collision by holding the software mask and the engine pulse in the same cycle on the locked mailbox. A behavioural model, which applies the set-wins rule bit by bit, judges every bitmap each cycle. Directed checks then confirm that the surviving bit is still visible one cycle later, and that the block retires a surviving cancel on the now unlocked mailbox.

// File: rtl/tx_sched_pkg.sv
package tx_sched_pkg;
    // Default geometry of the mailbox array
    localparam int unsigned MB_COUNT_DEF  = 32;
    localparam int unsigned PRIO_BITS_DEF = 5;
    localparam int unsigned COMPAT_MB_DEF = 16;

    typedef enum logic {
        PICK_BY_PRIO  = 1'b0,
        PICK_BY_INDEX = 1'b1
    } pick_mode_e;
endpackage

// File: rtl/tx_cand_mask.sv
module tx_cand_mask #(
    parameter int unsigned NUM_MB    = 32,
    parameter int unsigned COMPAT_MB = 16
) (
    input  logic              compat,
    input  logic [NUM_MB-1:0] pend,
    input  logic [NUM_MB-1:0] cancel,
    input  logic [NUM_MB-1:0] enable,
    input  logic [NUM_MB-1:0] is_rx,
    output logic [NUM_MB-1:0] elig
);
    // One qualifier per mailbox; upper mailboxes drop out in compatibility mode
    for (genvar gi = 0; gi < NUM_MB; gi++) begin : g_mb
        logic base_ok;
        assign base_ok = pend[gi] & enable[gi] & ~is_rx[gi] & ~cancel[gi];
        if (gi < COMPAT_MB) begin : g_low
            assign elig[gi] = base_ok;
        end else begin : g_high
            assign elig[gi] = base_ok & ~compat;
        end
    end
endmodule

// File: rtl/tx_prio_pick.sv
module tx_prio_pick
    import tx_sched_pkg::*;
#(
    parameter int unsigned NUM_MB = 32,
    parameter int unsigned PRIO_W = 5,
    localparam int unsigned IDX_W = $clog2(NUM_MB)
) (
    input  pick_mode_e               mode,
    input  logic [NUM_MB-1:0]        elig,
    input  logic [NUM_MB*PRIO_W-1:0] prio_flat,
    output logic                     found,
    output logic [IDX_W-1:0]         pick
);
    logic [PRIO_W-1:0] best;
    logic [PRIO_W-1:0] key;

    // Ascending scan with >= so that a later (higher) index wins a tie
    always_comb begin
        found = 1'b0;
        pick  = '0;
        best  = '0;
        key   = '0;
        for (int i = 0; i < NUM_MB; i++) begin
            key = (mode == PICK_BY_INDEX) ? '0 : prio_flat[i*PRIO_W +: PRIO_W];
            if (elig[i] && (!found || key >= best)) begin
                found = 1'b1;
                best  = key;
                pick  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tx_mbox_sched.sv
module tx_mbox_sched
    import tx_sched_pkg::*;
#(
    parameter int unsigned NUM_MB    = MB_COUNT_DEF,
    parameter int unsigned PRIO_W    = PRIO_BITS_DEF,
    parameter int unsigned COMPAT_MB = COMPAT_MB_DEF,
    localparam int unsigned IDX_W    = $clog2(NUM_MB)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     compat_mode,
    input  logic [NUM_MB-1:0]        mb_enable,
    input  logic [NUM_MB-1:0]        mb_is_rx,
    input  logic [NUM_MB*PRIO_W-1:0] mb_prio,
    input  logic [NUM_MB-1:0]        sw_req_set,
    input  logic [NUM_MB-1:0]        sw_cancel_set,
    input  logic [NUM_MB-1:0]        sw_tack_clr,
    input  logic [NUM_MB-1:0]        sw_aack_clr,
    input  logic                     eng_bus_idle,
    input  logic                     eng_done,
    input  logic                     eng_abort,
    output logic                     eng_start,
    output logic [IDX_W-1:0]         eng_mb_idx,
    output logic                     eng_cancel,
    output logic [NUM_MB-1:0]        tx_pending,
    output logic [NUM_MB-1:0]        tx_cancel,
    output logic [NUM_MB-1:0]        tx_ack,
    output logic [NUM_MB-1:0]        tx_abort_ack,
    output logic                     abort_irq
);
    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  cur;
        logic              start;
        logic [NUM_MB-1:0] pend;
        logic [NUM_MB-1:0] canc;
        logic [NUM_MB-1:0] tack;
        logic [NUM_MB-1:0] aack;
    } sched_st_t;

    sched_st_t st_d, st_q;

    logic [NUM_MB-1:0] elig;
    logic              pick_found;
    logic [IDX_W-1:0]  pick_idx;
    pick_mode_e        pick_mode;

    assign pick_mode = compat_mode ? PICK_BY_INDEX : PICK_BY_PRIO;

    tx_cand_mask #(.NUM_MB(NUM_MB), .COMPAT_MB(COMPAT_MB)) u_cand (
        .compat (compat_mode),
        .pend   (st_q.pend),
        .cancel (st_q.canc),
        .enable (mb_enable),
        .is_rx  (mb_is_rx),
        .elig   (elig)
    );

    tx_prio_pick #(.NUM_MB(NUM_MB), .PRIO_W(PRIO_W)) u_pick (
        .mode      (pick_mode),
        .elig      (elig),
        .prio_flat (mb_prio),
        .found     (pick_found),
        .pick      (pick_idx)
    );

    logic [NUM_MB-1:0] lock_mask, fin_mask, stray_canc, abort_now;
    logic [NUM_MB-1:0] pend_clr, canc_clr, tack_set, aack_set;

    always_comb begin
        st_d = st_q;

        lock_mask  = st_q.busy ? ({{(NUM_MB-1){1'b0}}, 1'b1} << st_q.cur) : '0;
        fin_mask   = (eng_done || eng_abort) ? lock_mask : '0;
        stray_canc = st_q.canc & ~lock_mask;
        abort_now  = stray_canc & st_q.pend;

        pend_clr = fin_mask | abort_now;
        canc_clr = fin_mask | stray_canc;
        tack_set = eng_done ? lock_mask : '0;
        aack_set = ((!eng_done && eng_abort) ? lock_mask : '0) | abort_now;

        st_d.start = 1'b0;
        if (st_q.busy && (eng_done || eng_abort)) begin
            st_d.busy = 1'b0;
        end else if (!st_q.busy && eng_bus_idle && pick_found) begin
            st_d.busy  = 1'b1;
            st_d.cur   = pick_idx;
            st_d.start = 1'b1;
        end

        // Set wins over a simultaneous clear, for every bitmap
        st_d.pend = (st_q.pend & ~pend_clr)    | sw_req_set;
        st_d.canc = (st_q.canc & ~canc_clr)    | sw_cancel_set;
        st_d.tack = (st_q.tack & ~sw_tack_clr) | tack_set;
        st_d.aack = (st_q.aack & ~sw_aack_clr) | aack_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eng_start    = st_q.start;
    assign eng_mb_idx   = st_q.cur;
    assign eng_cancel   = st_q.busy & st_q.canc[st_q.cur];
    assign tx_pending   = st_q.pend;
    assign tx_cancel    = st_q.canc;
    assign tx_ack       = st_q.tack;
    assign tx_abort_ack = st_q.aack;
    assign abort_irq    = |st_q.aack;

    // ---------------- assertions ----------------
    a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    a_r6_start_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> $past(eng_bus_idle));

    a_r6_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !eng_done && !eng_abort) |=> (st_q.busy && $stable(eng_mb_idx)));

    a_r5_compat_range: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (!$past(compat_mode) || (eng_mb_idx < IDX_W'(COMPAT_MB))));

    a_r7_done_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && eng_done) |=> (tx_ack[$past(eng_mb_idx)] && !tx_pending[$past(eng_mb_idx)] || $past(sw_req_set[eng_mb_idx])));

    a_r8_abort_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && eng_abort && !eng_done) |=> (tx_abort_ack[$past(eng_mb_idx)] && abort_irq));

    a_r2_req_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|sw_req_set) |=> ((tx_pending & $past(sw_req_set)) == $past(sw_req_set)));

    a_r10_cancel_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|sw_cancel_set) |=> ((tx_cancel & $past(sw_cancel_set)) == $past(sw_cancel_set)));
endmodule

// File: tb/sim_tx_mbox_sched.sv
module sim_tx_mbox_sched;
    localparam int CLK_PERIOD = 10;
    localparam int NMB = 32;
    localparam int PW  = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            compat_mode = 1'b0;
    logic [NMB-1:0]  mb_enable = '1;
    logic [NMB-1:0]  mb_is_rx = '0;
    logic [NMB*PW-1:0] mb_prio = '0;
    logic [NMB-1:0]  sw_req_set = '0, sw_cancel_set = '0, sw_tack_clr = '0, sw_aack_clr = '0;
    logic            eng_bus_idle = 1'b0, eng_done = 1'b0, eng_abort = 1'b0;
    logic            eng_start, eng_cancel, abort_irq;
    logic [4:0]      eng_mb_idx;
    logic [NMB-1:0]  tx_pending, tx_cancel, tx_ack, tx_abort_ack;

    int vectors = 0;
    int misses  = 0;
    string phase = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_mbox_sched u0 (
        .clk(clk), .rst_n(rst_n), .compat_mode(compat_mode),
        .mb_enable(mb_enable), .mb_is_rx(mb_is_rx), .mb_prio(mb_prio),
        .sw_req_set(sw_req_set), .sw_cancel_set(sw_cancel_set),
        .sw_tack_clr(sw_tack_clr), .sw_aack_clr(sw_aack_clr),
        .eng_bus_idle(eng_bus_idle), .eng_done(eng_done), .eng_abort(eng_abort),
        .eng_start(eng_start), .eng_mb_idx(eng_mb_idx), .eng_cancel(eng_cancel),
        .tx_pending(tx_pending), .tx_cancel(tx_cancel), .tx_ack(tx_ack),
        .tx_abort_ack(tx_abort_ack), .abort_irq(abort_irq)
    );

    // ---------------- behavioural reference ----------------
    bit [NMB-1:0] m_pend, m_canc, m_tack, m_aack;
    bit m_busy, m_start;
    int m_cur;

    function automatic int ref_pick();
        int top_p;
        int sel;
        top_p = -1;
        sel   = -1;
        for (int i = 0; i < NMB; i++) begin
            if (m_pend[i] && mb_enable[i] && !mb_is_rx[i] && !m_canc[i] && !(compat_mode && i >= 16)) begin
                if (compat_mode) sel = i;
                else if (int'(mb_prio[i*PW +: PW]) > top_p) top_p = int'(mb_prio[i*PW +: PW]);
            end
        end
        if (!compat_mode && top_p >= 0) begin
            for (int i = NMB-1; i >= 0; i--) begin
                if (sel < 0 && m_pend[i] && mb_enable[i] && !mb_is_rx[i] && !m_canc[i]
                    && int'(mb_prio[i*PW +: PW]) == top_p) sel = i;
            end
        end
        return sel;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_canc = '0; m_tack = '0; m_aack = '0;
            m_busy = 0; m_start = 0; m_cur = 0;
        end else begin
            bit [NMB-1:0] p, c, t, a;
            int s;
            p = m_pend; c = m_canc; t = m_tack; a = m_aack;
            s = ref_pick();
            m_start = 0;
            for (int i = 0; i < NMB; i++) begin
                if (m_busy && i == m_cur) begin
                    if (eng_done) begin p[i] = 0; c[i] = 0; t[i] = 1; end
                    else if (eng_abort) begin p[i] = 0; c[i] = 0; a[i] = 1; end
                end else if (m_canc[i]) begin
                    c[i] = 0;
                    if (m_pend[i]) begin p[i] = 0; a[i] = 1; end
                end
            end
            if (m_busy) begin
                if (eng_done || eng_abort) m_busy = 0;
            end else if (eng_bus_idle && s >= 0) begin
                m_busy = 1; m_cur = s; m_start = 1;
            end
            for (int i = 0; i < NMB; i++) begin
                if (sw_req_set[i])    p[i] = 1;
                if (sw_cancel_set[i]) c[i] = 1;
                if (sw_tack_clr[i] && !(t[i] && !m_tack[i])) t[i] = 0;
                if (sw_aack_clr[i] && !(a[i] && !m_aack[i])) a[i] = 0;
            end
            m_pend = p; m_canc = c; m_tack = t; m_aack = a;
        end
    end

    task automatic cmp(string what, logic [NMB-1:0] act, logic [NMB-1:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            cmp("pending", tx_pending, m_pend);
            cmp("cancel", tx_cancel, m_canc);
            cmp("ack", tx_ack, m_tack);
            cmp("abort_ack", tx_abort_ack, m_aack);
            cmp("abort_irq", NMB'(abort_irq), NMB'(|m_aack));
            cmp("start", NMB'(eng_start), NMB'(m_start));
            cmp("eng_cancel", NMB'(eng_cancel), NMB'(m_busy && m_canc[m_cur]));
            if (m_busy) cmp("mb_idx", NMB'(eng_mb_idx), NMB'(m_cur));
        end
    end

    // ---------------- directed checks ----------------
    task automatic chk(string rq, int act, int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        sw_req_set = '0; sw_cancel_set = '0; sw_tack_clr = '0; sw_aack_clr = '0;
        eng_done = 0; eng_abort = 0;
    endtask

    task automatic wait_start(output int idx);
        idx = -1;
        for (int k = 0; k < 30 && idx < 0; k++) begin
            tick();
            if (eng_start) idx = int'(eng_mb_idx);
        end
    endtask

    task automatic set_prio(int i, int p);
        mb_prio[i*PW +: PW] = PW'(p);
    endtask

    task automatic finish_it();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        misses++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_it();
    end

    initial begin
        int got;
        int starts;
        repeat (3) tick();
        rst_n = 1;
        tick();
        phase = "R1";
        chk("R1 pending after reset", int'(|tx_pending), 0);
        chk("R1 ack after reset", int'(|tx_ack | |tx_abort_ack | |tx_cancel), 0);
        chk("R1 start after reset", int'(eng_start), 0);

        // R2 and R6: requests accumulate while the bus is not idle
        phase = "R2";
        mb_enable[7] = 0;
        mb_is_rx[8]  = 1;
        set_prio(3, 20); set_prio(10, 20); set_prio(31, 5); set_prio(7, 31); set_prio(8, 30);
        sw_req_set = (1<<3) | (1<<10) | (1<<31) | (1<<7) | (1<<8);
        tick();
        chk("R2 pending set", int'(tx_pending == ((1<<3)|(1<<10)|(1<<31)|(1<<7)|(1<<8))), 1);
        sw_req_set = '0;
        tick();
        chk("R2 zero write keeps bits", int'(tx_pending[10]), 1);
        phase = "R6";
        starts = 0;
        for (int k = 0; k < 4; k++) begin tick(); if (eng_start) starts++; end
        chk("R6 no start without idle bus", starts, 0);

        // R4 and R3: priority order with excluded mailboxes
        phase = "R4";
        eng_bus_idle = 1;
        wait_start(got);
        chk("R4 tie goes to higher index", got, 10);
        tick();
        chk("R6 start is single pulse", int'(eng_start), 0);
        tick();
        chk("R6 index held while locked", int'(eng_mb_idx), 10);
        eng_done = 1;
        tick();
        phase = "R7";
        chk("R7 ack after done", int'(tx_ack[10]), 1);
        chk("R7 pending cleared", int'(tx_pending[10]), 0);
        phase = "R4";
        wait_start(got);
        chk("R4 next priority", got, 3);
        eng_done = 1; tick();
        wait_start(got);
        chk("R4 lowest priority last", got, 31);
        eng_done = 1; tick();
        phase = "R3";
        starts = 0;
        for (int k = 0; k < 5; k++) begin tick(); if (eng_start) starts++; end
        chk("R3 disabled and receive mailboxes never start", starts, 0);
        chk("R3 excluded requests stay pending", int'(tx_pending == ((1<<7)|(1<<8))), 1);

        // R9 and R8: cancel of unlocked pending mailboxes
        phase = "R9";
        sw_cancel_set = (1<<7) | (1<<8);
        tick();
        chk("R9 cancel visible", int'(tx_cancel[7]), 1);
        tick();
        chk("R9 unlocked cancel aborts", int'(tx_abort_ack == ((1<<7)|(1<<8))), 1);
        chk("R9 pending removed", int'(|tx_pending), 0);
        phase = "R8";
        chk("R8 irq follows abort ack", int'(abort_irq), 1);
        sw_aack_clr = '1; sw_tack_clr = '1;
        tick();
        chk("R11 clear by one", int'(|tx_abort_ack | |tx_ack), 0);

        // R5: compatibility mode
        phase = "R5";
        compat_mode = 1;
        set_prio(2, 31);
        sw_req_set = (1<<2) | (1<<15) | (1<<20);
        wait_start(got);
        chk("R5 highest index wins", got, 15);
        eng_done = 1; tick();
        wait_start(got);
        chk("R5 priority ignored", got, 2);
        eng_done = 1; tick();
        starts = 0;
        for (int k = 0; k < 4; k++) begin tick(); if (eng_start) starts++; end
        chk("R3 upper mailbox excluded in compat", starts, 0);
        sw_cancel_set = (1<<20);
        tick(); tick();
        sw_aack_clr = '1; sw_tack_clr = '1;
        tick();
        compat_mode = 0;

        // R9: cancel on the locked mailbox, then abort
        phase = "R9";
        sw_req_set = (1<<9);
        wait_start(got);
        chk("R9 locked mailbox", got, 9);
        sw_cancel_set = (1<<9);
        tick();
        chk("R9 cancel shown to engine", int'(eng_cancel), 1);
        tick();
        chk("R9 locked cancel held", int'(tx_cancel[9]), 1);
        eng_abort = 1;
        tick();
        phase = "R8";
        chk("R8 abort ack", int'(tx_abort_ack[9]), 1);
        chk("R8 cancel cleared by abort", int'(tx_cancel[9]), 0);
        sw_aack_clr = '1;
        tick();

        // R10: software sets collide with completion
        phase = "R10";
        sw_req_set = (1<<4);
        wait_start(got);
        eng_bus_idle = 0;
        eng_done = 1; sw_cancel_set = (1<<4); sw_req_set = (1<<4);
        tick();
        chk("R10 cancel set wins", int'(tx_cancel[4]), 1);
        chk("R10 request set wins", int'(tx_pending[4]), 1);
        chk("R7 ack on collision", int'(tx_ack[4]), 1);
        tick();
        chk("R9 surviving cancel retired", int'(tx_cancel[4]), 0);
        chk("R9 surviving request aborted", int'(tx_abort_ack[4]), 1);

        // R11: zero write, and set against clear
        phase = "R11";
        sw_aack_clr = '0;
        tick();
        chk("R11 zero write no effect", int'(tx_abort_ack[4]), 1);
        sw_aack_clr = (1<<4);
        tick();
        chk("R11 clear works", int'(tx_abort_ack[4]), 0);
        eng_bus_idle = 1;
        sw_req_set = (1<<6);
        wait_start(got);
        eng_abort = 1; sw_aack_clr = (1<<6);
        tick();
        chk("R11 hardware set wins", int'(tx_abort_ack[6]), 1);
        eng_done = 0;
        sw_req_set = (1<<12);
        wait_start(got);
        eng_done = 1; eng_abort = 1;
        tick();
        phase = "R7";
        chk("R7 done wins over abort", int'(tx_ack[12]), 1);
        chk("R7 no abort ack on tie", int'(tx_abort_ack[12]), 0);
        repeat (3) tick();
        finish_it();
    end
endmodule